// File: doc/BRIEF.md
# Indirect Interrupt Controller Register Window

This block is the register front end of an interrupt routing controller. A bus master sees only two 32-bit locations: an 8-bit select register and a data window. It first writes an index into the select register. Reads and writes at the window then reach the register that index names:

- the identification register,
- the version register,
- the arbitration register,
- or one 32-bit half of a 64-bit redirection entry, with one entry per interrupt pin.

All redirection entries are held here and are exposed as one flat vector to a separate delivery block. The same delivery block receives two one-cycle pulse vectors: "entry written" and "mask changed". It drives back one set request per pin for the remote-IRR status bit. Writing the low half of an entry clears that bit.

The bus is a simple single-cycle interface with byte enables. Read data is combinational in the cycle of the access. Writes take effect at the clock edge that ends the access cycle.

Top module: `irq_regwin`

## Requirements
- R1: Offset 0x00 holds an 8-bit select register. A write with byte enable 0 set loads `bus_wdata[7:0]`, and a write without it leaves the register unchanged. A read returns the value zero-extended.
- R2: A bus offset other than 0x00 and 0x10 reads as zero. A write to such an offset changes no register.
- R3: Select value 0x01 reads as `{8'h00, NUM_PINS-1, 8'h00, VERSION}`, which is 32'h0017_0011 with the defaults. Writes to it are ignored.
- R4: At select value 0x00, the identification register sits in bits 27:24, and a window write with byte enable 3 set loads it. Select value 0x02 reads the same value, and writes there are ignored. Select values 0x03 to 0x0F read zero, and writes there are ignored.
- R5: Select value S ≥ 0x10 reaches entry (S−0x10)/2. An even S reaches bits 31:0 and an odd S reaches bits 63:32. A write replaces only the bytes whose enable is set.
- R6: A low-half write with any byte enable set clears remote-IRR (bit 14), whatever the data says. A high-half write leaves bits 31:0 unchanged.
- R7: A pulse on `rirr_set[i]` sets bit 14 of entry i at the next edge. It wins over a low-half write to the same entry in the same cycle.
- R8: A select value that maps to an entry index ≥ NUM_PINS reads zero. A window write with such a value changes nothing and raises no pulse.
- R9: After reset, every entry is 64'h0000_0000_0001_0000 (mask bit 16 set, all else zero), and the select and identification registers are zero.
- R10: A window write with any byte enable set to an in-range entry raises `entry_wr_pulse[i]` for exactly the one cycle that follows it.
- R11: `mask_chg_pulse[i]` is high for the one cycle after a write that flipped bit 16 of entry i, and only then.
- R12: Entry i appears on `entry_flat[64*i+63:64*i]`. Its fields are: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote-IRR 14, trigger mode 15, mask 16, destination 63:56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset inside the block |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the read cycle |
| rirr_set | input | NUM_PINS | Per-pin remote-IRR set request |
| entry_flat | output | 64*NUM_PINS | All redirection entries |
| entry_wr_pulse | output | NUM_PINS | Entry written, one cycle |
| mask_chg_pulse | output | NUM_PINS | Mask bit flipped, one cycle |

## Verification
The bench builds the block with its defaults: 24 pins, version code 0x11 and a 4-bit identification field. With 24 pins, select values from 0x40 up fall outside the table, so the out-of-range path is reached with ordinary select writes. The 0x3E/0x3F pair reaches the last entry at the top of the flat vector. A random phase mixes select, window and stray-offset accesses with partial byte enables and remote-IRR set pulses, and the reference model follows every cycle of it.

// File: rtl/irq_regwin_pkg.sv
package irq_regwin_pkg;

   // bus offsets
   localparam logic [7:0] OFS_SELECT = 8'h00;
   localparam logic [7:0] OFS_WINDOW = 8'h10;

   // select values for the small registers
   localparam logic [7:0] SEL_IDENT  = 8'h00;
   localparam logic [7:0] SEL_VER    = 8'h01;
   localparam logic [7:0] SEL_ARB    = 8'h02;
   localparam logic [7:0] SEL_ENTRY0 = 8'h10;

   // entry field positions the neighbours decode
   localparam int BIT_RIRR = 14;
   localparam int BIT_MASK = 16;

   localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_IDENT,
      TGT_VER,
      TGT_ARB,
      TGT_ENTRY
   } tgt_e;

   function automatic logic [31:0] be_merge(input logic [31:0] cur,
                                            input logic [31:0] nw,
                                            input logic [3:0]  be);
      logic [31:0] res;
      res = cur;
      for (int b = 0; b < 4; b++) begin
         if (be[b]) res[8*b +: 8] = nw[8*b +: 8];
      end
      return res;
   endfunction

endpackage

// File: rtl/irq_regwin_decode.sv
module irq_regwin_decode
   import irq_regwin_pkg::*;
#(
   parameter int NUM_PINS = 24,
   parameter int IDX_W    = 5
) (
   input  logic [7:0]       sel_i,
   output tgt_e             tgt_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             hi_o
);

   logic [6:0] raw_idx;

   always_comb begin
      raw_idx = sel_i[7:1] - 7'd8;
      hi_o    = sel_i[0];
      idx_o   = raw_idx[IDX_W-1:0];
      if (sel_i >= SEL_ENTRY0) begin
         tgt_o = (int'({1'b0, raw_idx}) < NUM_PINS) ? TGT_ENTRY : TGT_NONE;
      end else begin
         unique case (sel_i)
            SEL_IDENT: tgt_o = TGT_IDENT;
            SEL_VER:   tgt_o = TGT_VER;
            SEL_ARB:   tgt_o = TGT_ARB;
            default:   tgt_o = TGT_NONE;
         endcase
      end
   end

endmodule

// File: rtl/irq_regwin_entry.sv
module irq_regwin_entry
   import irq_regwin_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_lo_i,
   input  logic        wr_hi_i,
   input  logic [31:0] wdata_i,
   input  logic [3:0]  be_i,
   input  logic        rirr_set_i,
   output logic [63:0] ent_o,
   output logic        wr_pulse_o,
   output logic        mask_chg_o
);

   logic [63:0] ent_q, ent_d;
   logic        wr_pulse_q, mask_chg_q;

   always_comb begin
      ent_d = ent_q;
      if (wr_lo_i) begin
         ent_d[31:0]     = be_merge(ent_q[31:0], wdata_i, be_i);
         ent_d[BIT_RIRR] = 1'b0;
      end
      if (wr_hi_i) begin
         ent_d[63:32] = be_merge(ent_q[63:32], wdata_i, be_i);
      end
      if (rirr_set_i) begin
         ent_d[BIT_RIRR] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_q      <= ENTRY_RST;
         wr_pulse_q <= 1'b0;
         mask_chg_q <= 1'b0;
      end else begin
         ent_q      <= ent_d;
         wr_pulse_q <= wr_lo_i | wr_hi_i;
         mask_chg_q <= ent_d[BIT_MASK] ^ ent_q[BIT_MASK];
      end
   end

   assign ent_o      = ent_q;
   assign wr_pulse_o = wr_pulse_q;
   assign mask_chg_o = mask_chg_q;

   // R11
   mask_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_chg_q |-> (ent_q[BIT_MASK] != $past(ent_q[BIT_MASK])));

   // R6
   rirr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo_i && !rirr_set_i) |=> !ent_q[BIT_RIRR]);

   // R6
   low_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi_i && !wr_lo_i && !rirr_set_i) |=> $stable(ent_q[31:0]));

   // R7
   rirr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rirr_set_i |=> ent_q[BIT_RIRR]);

   // R10
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo_i || wr_hi_i) |=> wr_pulse_q);

endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
   import irq_regwin_pkg::*;
#(
   parameter int         NUM_PINS = 24,
   parameter logic [7:0] VERSION  = 8'h11,
   parameter int         ID_W     = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_en,
   input  logic                  bus_wr,
   input  logic [7:0]            bus_addr,
   input  logic [3:0]            bus_be,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   input  logic [NUM_PINS-1:0]   rirr_set,
   output logic [64*NUM_PINS-1:0] entry_flat,
   output logic [NUM_PINS-1:0]   entry_wr_pulse,
   output logic [NUM_PINS-1:0]   mask_chg_pulse
);

   localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
   localparam int MAX_PIN = (256 - 16) / 2;

   if (NUM_PINS < 1 || NUM_PINS > MAX_PIN) begin : g_bad_pins
      $error("irq_regwin: NUM_PINS out of range");
   end
   if (ID_W < 1 || ID_W > 8) begin : g_bad_idw
      $error("irq_regwin: ID_W out of range");
   end

   logic [7:0]       sel_q;
   logic [ID_W-1:0]  id_q;
   tgt_e             tgt;
   logic [IDX_W-1:0] idx;
   logic             hi;
   logic             win_wr, sel_wr;
   logic [63:0]      ent_arr [NUM_PINS];
   logic [63:0]      ent_pick;

   assign sel_wr = bus_en && bus_wr && (bus_addr == OFS_SELECT);
   assign win_wr = bus_en && bus_wr && (bus_addr == OFS_WINDOW) && (|bus_be);

   irq_regwin_decode #(
      .NUM_PINS (NUM_PINS),
      .IDX_W    (IDX_W)
   ) i_decode (
      .sel_i (sel_q),
      .tgt_o (tgt),
      .idx_o (idx),
      .hi_o  (hi)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         id_q  <= '0;
      end else begin
         if (sel_wr && bus_be[0]) sel_q <= bus_wdata[7:0];
         if (win_wr && tgt == TGT_IDENT && bus_be[3]) id_q <= bus_wdata[24 +: ID_W];
      end
   end

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
      logic hit;
      assign hit = win_wr && (tgt == TGT_ENTRY) && (idx == IDX_W'(g));

      irq_regwin_entry i_entry (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_lo_i    (hit && !hi),
         .wr_hi_i    (hit && hi),
         .wdata_i    (bus_wdata),
         .be_i       (bus_be),
         .rirr_set_i (rirr_set[g]),
         .ent_o      (ent_arr[g]),
         .wr_pulse_o (entry_wr_pulse[g]),
         .mask_chg_o (mask_chg_pulse[g])
      );

      assign entry_flat[64*g +: 64] = ent_arr[g];
   end

   always_comb begin
      ent_pick = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (idx == IDX_W'(i)) ent_pick = ent_arr[i];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_en && !bus_wr) begin
         if (bus_addr == OFS_SELECT) begin
            bus_rdata[7:0] = sel_q;
         end else if (bus_addr == OFS_WINDOW) begin
            unique case (tgt)
               TGT_IDENT, TGT_ARB: bus_rdata[24 +: ID_W] = id_q;
               TGT_VER: begin
                  bus_rdata[23:16] = 8'(NUM_PINS - 1);
                  bus_rdata[7:0]   = VERSION;
               end
               TGT_ENTRY: bus_rdata = hi ? ent_pick[63:32] : ent_pick[31:0];
               default: bus_rdata = '0;
            endcase
         end
      end
   end

   // R2
   stray_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_wr && bus_addr != OFS_SELECT) |=> $stable(sel_q));

   // R4
   id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_wr && sel_q != SEL_IDENT) |=> $stable(id_q));

   // R8
   oor_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && tgt == TGT_NONE) |=> (entry_wr_pulse == '0));

   // R10
   pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(entry_wr_pulse));

endmodule

// File: tb/test_irq_regwin.sv
module test_irq_regwin;

   localparam int NP = 24;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_en = 1'b0, bus_wr = 1'b0;
   logic [7:0]        bus_addr = '0;
   logic [3:0]        bus_be = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NP-1:0]     rirr_set = '0;
   logic [64*NP-1:0]  entry_flat;
   logic [NP-1:0]     entry_wr_pulse, mask_chg_pulse;

   irq_regwin i_irq_regwin (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .rirr_set(rirr_set), .entry_flat(entry_flat),
      .entry_wr_pulse(entry_wr_pulse), .mask_chg_pulse(mask_chg_pulse)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;

   // reference model
   logic [63:0] m_ent [NP];
   logic [7:0]  m_sel;
   logic [3:0]  m_id;
   logic [NP-1:0] m_wp, m_mc;

   function automatic logic [31:0] mix(input logic [31:0] o, input logic [31:0] n,
                                       input logic [3:0] be);
      logic [31:0] r = o;
      for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
      return r;
   endfunction

   function automatic logic [31:0] m_read(input logic [7:0] a);
      int ix;
      if (a == 8'h00) return {24'h0, m_sel};
      if (a != 8'h10) return 32'h0;
      if (m_sel == 8'h00 || m_sel == 8'h02) return {4'h0, m_id, 24'h0};
      if (m_sel == 8'h01) return 32'h0017_0011;
      if (m_sel < 8'h10) return 32'h0;
      ix = (int'(m_sel) - 16) / 2;
      if (ix >= NP) return 32'h0;
      return m_sel[0] ? m_ent[ix][63:32] : m_ent[ix][31:0];
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NP; i++) m_ent[i] = 64'h0000_0000_0001_0000;
      m_sel = '0; m_id = '0; m_wp = '0; m_mc = '0;
   endtask

   task automatic check(input logic ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic compare_state(input string req);
      for (int i = 0; i < NP; i++) begin
         check(entry_flat[64*i +: 64] === m_ent[i], {req, " R12 entry"},
               entry_flat[64*i +: 64], m_ent[i]);
      end
      check(entry_wr_pulse === m_wp, {req, " R10 wr pulse"}, 64'(entry_wr_pulse), 64'(m_wp));
      check(mask_chg_pulse === m_mc, {req, " R11 mask pulse"}, 64'(mask_chg_pulse), 64'(m_mc));
   endtask

   // one bus cycle; called at a falling edge
   task automatic op(input logic en, input logic wr, input logic [7:0] a,
                     input logic [31:0] d, input logic [3:0] be,
                     input logic [NP-1:0] set, input string req);
      logic [63:0] old [NP];
      int ix;
      bus_en = en; bus_wr = wr; bus_addr = a; bus_wdata = d; bus_be = be; rirr_set = set;
      #1;
      if (en && !wr) check(bus_rdata === m_read(a), req, 64'(bus_rdata), 64'(m_read(a)));
      @(posedge clk);
      for (int i = 0; i < NP; i++) old[i] = m_ent[i];
      m_wp = '0;
      if (en && wr && a == 8'h00 && be[0]) m_sel = d[7:0];
      else if (en && wr && a == 8'h10 && be != 4'h0) begin
         if (m_sel == 8'h00 && be[3]) m_id = d[27:24];
         else if (m_sel >= 8'h10) begin
            ix = (int'(m_sel) - 16) / 2;
            if (ix < NP) begin
               if (m_sel[0]) m_ent[ix][63:32] = mix(m_ent[ix][63:32], d, be);
               else begin
                  m_ent[ix][31:0] = mix(m_ent[ix][31:0], d, be);
                  m_ent[ix][14] = 1'b0;
               end
               m_wp[ix] = 1'b1;
            end
         end
      end
      for (int i = 0; i < NP; i++) begin
         if (set[i]) m_ent[i][14] = 1'b1;
         m_mc[i] = m_ent[i][16] ^ old[i][16];
      end
      @(negedge clk);
      bus_en = 0; bus_wr = 0; rirr_set = '0;
      compare_state(req);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
      op(1, 1, a, d, 4'hF, '0, req);
   endtask

   task automatic rd(input logic [7:0] a, input string req);
      op(1, 0, a, 32'h0, 4'h0, '0, req);
   endtask

   initial begin
      #(8 * 200000);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      compare_state("R9");
      rd(8'h00, "R9 R1 select reset");
      rd(8'h10, "R9 R4 ident reset");

      // R3 version
      wr(8'h00, 32'hFFFF_FF01, "R1 select load");
      rd(8'h00, "R1 select readback");
      rd(8'h10, "R3 version read");
      wr(8'h10, 32'hFFFF_FFFF, "R3 version write");
      rd(8'h10, "R3 version unchanged");

      // R4 ident/arb
      wr(8'h00, 32'h0000_0000, "R1 select ident");
      wr(8'h10, 32'hA5FF_FFFF, "R4 ident write");
      rd(8'h10, "R4 ident read");
      op(1, 1, 8'h10, 32'h0300_0000, 4'h7, '0, "R4 ident no lane3");
      rd(8'h10, "R4 ident kept");
      wr(8'h00, 32'h0000_0002, "R1 select arb");
      rd(8'h10, "R4 arb read");
      wr(8'h10, 32'h0F00_0000, "R4 arb write ignored");
      rd(8'h10, "R4 arb after write");
      wr(8'h00, 32'h0000_0005, "R1 select reserved");
      wr(8'h10, 32'hFFFF_FFFF, "R4 reserved write");
      rd(8'h10, "R4 reserved reads zero");

      // R5 R6 R11 entry 0
      wr(8'h00, 32'h0000_0010, "R5 select entry0 lo");
      wr(8'h10, 32'h0000_E931, "R5 R11 unmask entry0");
      rd(8'h10, "R5 R6 entry0 lo readback");
      wr(8'h00, 32'h0000_0011, "R5 select entry0 hi");
      wr(8'h10, 32'hAB00_0000, "R6 hi write");
      rd(8'h10, "R5 entry0 hi readback");
      wr(8'h00, 32'h0000_0010, "R5 select entry0 lo");
      rd(8'h10, "R6 lo unchanged");
      // R7 set then clear by lo write with single lane
      op(0, 0, 8'h00, 0, 0, NP'(1), "R7 set rirr");
      rd(8'h10, "R7 rirr visible");
      op(1, 1, 8'h10, 32'h1234_5677, 4'h1, '0, "R6 R5 lane0 write clears rirr");
      rd(8'h10, "R5 R6 merged readback");
      op(1, 1, 8'h10, 32'h0000_0000, 4'h3, NP'(1), "R7 set beats clear");
      op(1, 1, 8'h10, 32'h0001_0000, 4'h0, '0, "R10 no lanes no write");
      op(1, 1, 8'h10, 32'h0001_0000, 4'h4, '0, "R11 re-mask");

      // last entry
      wr(8'h00, 32'h0000_003E, "R12 select last lo");
      wr(8'h10, 32'h0000_00FE, "R12 last lo write");
      wr(8'h00, 32'h0000_003F, "R12 select last hi");
      wr(8'h10, 32'h5500_0000, "R12 last hi write");
      rd(8'h10, "R12 last hi read");

      // R8 out of range
      wr(8'h00, 32'h0000_0040, "R8 select oor");
      wr(8'h10, 32'hFFFF_FFFF, "R8 oor write");
      rd(8'h10, "R8 oor read");
      wr(8'h00, 32'h0000_00FF, "R8 select top");
      wr(8'h10, 32'h0000_0000, "R8 top write");
      rd(8'h10, "R8 top read");

      // R2 stray offsets, R1 lane gating
      wr(8'h04, 32'h0000_0012, "R2 stray write");
      rd(8'h00, "R2 select unchanged");
      rd(8'h20, "R2 stray read");
      op(1, 1, 8'h00, 32'h0000_0013, 4'hE, '0, "R1 select without lane0");
      rd(8'h00, "R1 select kept");

      // random traffic
      for (int n = 0; n < 400; n++) begin
         int r;
         logic [7:0]  a;
         logic [31:0] d;
         logic [NP-1:0] s;
         r = $urandom % 8;
         a = (r < 3) ? 8'h00 : (r < 7) ? 8'h10 : 8'($urandom);
         d = $urandom;
         if (a == 8'h00 && ($urandom % 4) != 0) d[7:0] = 8'(16 + $urandom % 52);
         s = (($urandom % 4) == 0) ? (NP'(1) << ($urandom % NP)) : '0;
         op(1, 1'($urandom), a, d, 4'($urandom), s, "R5 R6 R7 R8 random");
      end

      op(0, 0, 8'h00, 0, 0, '0, "R10 idle");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule